// File: doc/BRIEF.md
# Closed-Loop Clamp Offset Calibrator

This block trims the black-level offset of a video converter without help from software. Each channel watches the converter's 8-bit output code while the clamp strobe is high. When the clamp window closes it compares the last code seen with a programmed target code. It then moves an internal offset accumulator one step up, when the code is too low, or one step down, when the code is too high. It makes no move when the two codes match. A signed trim is added to the accumulator, and the sum, saturated to the offset range, is the offset word sent to the converter.

A per-channel select chooses how the target is read. In ground mode the target is an absolute code. In midscale mode the target is a two's-complement distance from code 128. When a channel's loop is disabled, the programmed target field goes straight to the offset word as a raw offset, and the accumulator keeps its value for later. The channels are identical and independent, and their number is a parameter.

Top module: `aoc_offset_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel's accumulator returns to ACC_INIT (default 0) and its offset word returns to 0.
- R2: For an enabled channel, the comparison runs in the first cycle in which the clamp is low after a cycle in which it was high. The code is the one present in the last clamp-high cycle. If that code is below the effective target, the accumulator rises by 1. If it is above, the accumulator falls by 1. If it is equal, the accumulator is unchanged. With a plant whose code follows the offset, the loop therefore settles with the code exactly equal to the target.
- R3: The accumulator changes at most once per clamp interval, however long the interval is. It never changes while the clamp is high or idle.
- R4: The accumulator saturates at 0 and at 2^OFS_W-1 (255) and never wraps.
- R5: With the loop enabled, the offset word is accumulator + trim. The trim is TRIM_W-bit two's complement, -64..+63 by default. The sum saturates to 0..255. For example, 68 with +10 gives 78, and 68 with -10 gives 58.
- R6: With midscale select = 0, the effective target equals the target field. With select = 1, it is the target field with its most significant bit inverted, which is target + 128 modulo 256.
- R7: With the loop disabled, the offset word equals the target field, zero-extended. The accumulator holds its value, and clamp windows are ignored.
- R8: The offset word is registered. It reflects, one clock later, the accumulator, trim, target and enable present at the preceding edge.
- R9: Channels are independent. Stimulus on one channel never changes another channel's offset word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | NCH | Per-channel loop enable |
| clamp_i | input | NCH | Per-channel clamp strobe, high during the black reference |
| code_i | input | NCH*CODE_W | Converter output codes, channel c in bits [c*CODE_W +: CODE_W] |
| tgt_i | input | NCH*CODE_W | Programmed field: target code when enabled, raw offset when disabled |
| trim_i | input | NCH*TRIM_W | Signed offset trim per channel |
| mid_i | input | NCH | 1 = midscale clamp reference, 0 = ground |
| ofs_o | output | NCH*OFS_W | Offset word per channel |

## Verification
The bench builds the block with NCH=3, CODE_W=8, OFS_W=8, TRIM_W=7 and ACC_INIT=0. With an 8-bit accumulator stepping by one, both saturation rails are reached within a few hundred clamp pulses. With a 7-bit trim, the -64 and +63 extremes are easy to drive against the rails. Three channels let the bench show that they are independent. A closed loop, in which a behavioural plant's code follows the offset word plus a per-channel bias, demonstrates convergence in both target modes.

// File: rtl/aoc_pkg.sv
// Package: shared types for the clamp offset calibrator.
// Assumes: nothing beyond standard SystemVerilog.
package aoc_pkg;

    // Direction of the one-step accumulator correction decided per window
    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

endpackage

// File: rtl/aoc_window_sampler.sv
// Module: aoc_window_sampler
// Tracks the clamp strobe of one channel. It holds the converter code seen in
// the most recent clamp-high cycle and flags the first cycle after the window
// closes.
// Assumes: clamp_i is synchronous to clk. A window is at least one cycle long.
module aoc_window_sampler #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clamp_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              win_end_o,
    output logic [CODE_W-1:0] code_last_o
);

    logic              clamp_q;
    logic [CODE_W-1:0] code_q;

    // Register the strobe and capture the code while the clamp is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_q <= 1'b0;
            code_q  <= '0;
        end else begin
            clamp_q <= clamp_i;
            if (clamp_i) begin
                code_q <= code_i;
            end
        end
    end

    // Falling edge of the clamp marks the single decision cycle
    always_comb begin
        win_end_o   = clamp_q & ~clamp_i;
        code_last_o = code_q;
    end

    // R3
    win_end_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_o |=> !win_end_o);

endmodule

// File: rtl/aoc_target_cmp.sv
// Module: aoc_target_cmp
// Forms the effective target from the programmed field and the reference
// select, and decides the correction direction for one channel.
// Assumes: CODE_W >= 2. Midscale is half of the code range.
module aoc_target_cmp #(
    parameter int CODE_W = 8
) (
    input  logic              mid_i,
    input  logic [CODE_W-1:0] tgt_i,
    input  logic [CODE_W-1:0] code_i,
    output aoc_pkg::adj_e     adj_o
);

    localparam int MSB = CODE_W - 1;

    logic [CODE_W-1:0] eff_tgt;

    // Midscale reading treats the field as signed around half scale
    always_comb begin
        eff_tgt = {tgt_i[MSB] ^ mid_i, tgt_i[MSB-1:0]};
    end

    // Compare code against target: low -> raise offset, high -> lower it
    always_comb begin
        if (code_i < eff_tgt) begin
            adj_o = aoc_pkg::ADJ_UP;
        end else if (code_i > eff_tgt) begin
            adj_o = aoc_pkg::ADJ_DOWN;
        end else begin
            adj_o = aoc_pkg::ADJ_HOLD;
        end
    end

endmodule

// File: rtl/aoc_accum.sv
// Module: aoc_accum
// Saturating up/down offset accumulator of one channel. It moves by one LSB,
// only in a window-end cycle while enabled.
// Assumes: OFS_W >= 2, and 0 <= ACC_INIT <= 2**OFS_W-1.
module aoc_accum #(
    parameter int OFS_W    = 8,
    parameter int ACC_INIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             win_end_i,
    input  aoc_pkg::adj_e    adj_i,
    output logic [OFS_W-1:0] acc_o
);

    localparam logic [OFS_W-1:0] ACC_MAX = '1;
    localparam logic [OFS_W-1:0] INIT_V  = OFS_W'(ACC_INIT);

    logic [OFS_W-1:0] acc_q;
    logic             pv_q;

    // Step the accumulator once per closed window, clipping at both rails
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= INIT_V;
        end else if (en_i && win_end_i) begin
            case (adj_i)
                aoc_pkg::ADJ_UP:   if (acc_q != ACC_MAX) acc_q <= acc_q + 1'b1;
                aoc_pkg::ADJ_DOWN: if (acc_q != '0)      acc_q <= acc_q - 1'b1;
                default:           acc_q <= acc_q;
            endcase
        end
    end

    // Marks that at least one edge has passed since reset, for history checks
    always_ff @(posedge clk) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    assign acc_o = acc_q;

    // R7
    acc_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && !$past(en_i) |-> acc_q == $past(acc_q));

    // R3
    acc_only_at_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && !$past(win_end_i) |-> acc_q == $past(acc_q));

    // R4
    acc_top_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(acc_q) == ACC_MAX |-> acc_q != '0);

    // R4
    acc_bottom_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(acc_q) == '0 |-> acc_q != ACC_MAX);

    // R2
    acc_hold_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(adj_i) == aoc_pkg::ADJ_HOLD |-> acc_q == $past(acc_q));

endmodule

// File: rtl/aoc_trim_sum.sv
// Module: aoc_trim_sum
// Builds the registered offset word of one channel. When enabled, the word is
// the saturated sum of accumulator and signed trim. When disabled, it is the
// programmed field passed through.
// Assumes: OFS_W >= CODE_W and TRIM_W <= OFS_W + 1.
module aoc_trim_sum #(
    parameter int CODE_W = 8,
    parameter int OFS_W  = 8,
    parameter int TRIM_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [OFS_W-1:0]  acc_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic [CODE_W-1:0] tgt_i,
    output logic [OFS_W-1:0]  ofs_o
);

    localparam int SW = OFS_W + 2;
    localparam logic signed [SW-1:0] MAX_S = SW'((64'd1 << OFS_W) - 64'd1);

    logic signed [SW-1:0] acc_x;
    logic signed [SW-1:0] trim_x;
    logic signed [SW-1:0] sum_x;
    logic [OFS_W-1:0]     sum_sat;
    logic [OFS_W-1:0]     ofs_q;
    logic                 pv_q;

    // Widen both operands and clip the sum into the offset range
    always_comb begin
        acc_x  = signed'({2'b00, acc_i});
        trim_x = SW'($signed(trim_i));
        sum_x  = acc_x + trim_x;
        if (sum_x < 0) begin
            sum_sat = '0;
        end else if (sum_x > MAX_S) begin
            sum_sat = '1;
        end else begin
            sum_sat = sum_x[OFS_W-1:0];
        end
    end

    // Register the offset word: loop result or raw programmed field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (en_i) begin
            ofs_q <= sum_sat;
        end else begin
            ofs_q <= OFS_W'(tgt_i);
        end
    end

    // Marks that at least one edge has passed since reset, for history checks
    always_ff @(posedge clk) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    assign ofs_o = ofs_q;

    // R7
    ofs_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && !$past(en_i) |-> ofs_o == OFS_W'($past(tgt_i)));

    // R5
    ofs_trim_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(en_i) && !$past(trim_i[TRIM_W-1]) |-> ofs_o >= $past(acc_i));

    // R5
    ofs_trim_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(en_i) && $past(trim_i[TRIM_W-1]) |-> ofs_o <= $past(acc_i));

endmodule

// File: rtl/aoc_offset_loop.sv
// Module: aoc_offset_loop (top)
// NCH independent clamp offset calibration loops. Each channel samples its
// code at clamp end, steps a saturating accumulator toward the target, and
// outputs accumulator + trim (or the raw field when disabled).
// Assumes: all inputs synchronous to clk. Buses are packed per channel, with
// channel c in slice [c*W +: W].
module aoc_offset_loop #(
    parameter int NCH      = 3,
    parameter int CODE_W   = 8,
    parameter int OFS_W    = 8,
    parameter int TRIM_W   = 7,
    parameter int ACC_INIT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           en_i,
    input  logic [NCH-1:0]           clamp_i,
    input  logic [NCH*CODE_W-1:0]    code_i,
    input  logic [NCH*CODE_W-1:0]    tgt_i,
    input  logic [NCH*TRIM_W-1:0]    trim_i,
    input  logic [NCH-1:0]           mid_i,
    output logic [NCH*OFS_W-1:0]     ofs_o
);

    // One complete loop per channel, no shared state between channels
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic                win_end;
        logic [CODE_W-1:0]   code_last;
        aoc_pkg::adj_e       adj;
        logic [OFS_W-1:0]    acc;

        aoc_window_sampler #(.CODE_W(CODE_W)) u_win (
            .clk         (clk),
            .rst_n       (rst_n),
            .clamp_i     (clamp_i[c]),
            .code_i      (code_i[c*CODE_W +: CODE_W]),
            .win_end_o   (win_end),
            .code_last_o (code_last)
        );

        aoc_target_cmp #(.CODE_W(CODE_W)) u_cmp (
            .mid_i  (mid_i[c]),
            .tgt_i  (tgt_i[c*CODE_W +: CODE_W]),
            .code_i (code_last),
            .adj_o  (adj)
        );

        aoc_accum #(.OFS_W(OFS_W), .ACC_INIT(ACC_INIT)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_i[c]),
            .win_end_i (win_end),
            .adj_i     (adj),
            .acc_o     (acc)
        );

        aoc_trim_sum #(.CODE_W(CODE_W), .OFS_W(OFS_W), .TRIM_W(TRIM_W)) u_sum (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_i[c]),
            .acc_i  (acc),
            .trim_i (trim_i[c*TRIM_W +: TRIM_W]),
            .tgt_i  (tgt_i[c*CODE_W +: CODE_W]),
            .ofs_o  (ofs_o[c*OFS_W +: OFS_W])
        );
    end

endmodule

// File: tb/tb_aoc_offset_loop.sv
// Bench for aoc_offset_loop: directed corners, seeded random stimulus and a
// closed loop with a behavioural plant. A requirement-level model checks every
// cycle.
module tb_aoc_offset_loop;

    localparam int NCH = 3;
    localparam int CW  = 8;
    localparam int OW  = 8;
    localparam int TW  = 7;
    localparam int OMAX = 255;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NCH-1:0]       en, clamp, mid;
    logic [NCH*CW-1:0]    code, tgt;
    logic [NCH*TW-1:0]    trim;
    logic [NCH*OW-1:0]    ofs;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int m_acc [NCH];
    int m_ofs [NCH];
    int m_code[NCH];
    bit m_cp  [NCH];

    aoc_offset_loop #(.NCH(NCH), .CODE_W(CW), .OFS_W(OW), .TRIM_W(TW), .ACC_INIT(0)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .clamp_i(clamp), .code_i(code),
        .tgt_i(tgt), .trim_i(trim), .mid_i(mid), .ofs_o(ofs)
    );

    always #10 clk = ~clk;

    function automatic int sat(int v);
        if (v < 0) return 0;
        if (v > OMAX) return OMAX;
        return v;
    endfunction

    function automatic int trim_of(int c);
        int t = int'(trim[c*TW +: TW]);
        if (t >= 64) t -= 128;
        return t;
    endfunction

    function automatic int eff_tgt(int c);
        int t = int'(tgt[c*CW +: CW]);
        return mid[c] ? (t ^ 128) : t;
    endfunction

    function automatic int ofs_of(int c);
        return int'(ofs[c*OW +: OW]);
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_code(int c, int v); code[c*CW +: CW] = CW'(v); endtask
    task automatic set_tgt(int c, int v);  tgt[c*CW +: CW]  = CW'(v); endtask
    task automatic set_trim(int c, int v); trim[c*TW +: TW] = TW'(v); endtask

    // One clamp window on channel c, returning once ofs shows the new accumulator
    task automatic pulse(int c, int v, int len);
        set_code(c, v);
        clamp[c] = 1'b1;
        repeat (len) tick();
        clamp[c] = 1'b0;
        tick();
        tick();
    endtask

    // Reference model from the requirements, advanced at each clock edge
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_ofs[c] = 0;
                m_acc[c] = 0;
                m_cp[c]  = 1'b0;
                m_code[c] = 0;
            end else begin
                m_ofs[c] = en[c] ? sat(m_acc[c] + trim_of(c)) : int'(tgt[c*CW +: CW]);
                if (en[c] && m_cp[c] && !clamp[c]) begin
                    if (m_code[c] < eff_tgt(c))      m_acc[c] = sat(m_acc[c] + 1);
                    else if (m_code[c] > eff_tgt(c)) m_acc[c] = sat(m_acc[c] - 1);
                end
                m_cp[c] = clamp[c];
                if (clamp[c]) m_code[c] = int'(code[c*CW +: CW]);
            end
        end
    end

    // Every cycle: offset word against the model (R8 latency and all rules)
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < NCH; c++) check($sformatf("R8 ch%0d per-cycle", c), ofs_of(c), m_ofs[c]);
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bias[NCH];
        int goal[NCH];
        void'($urandom(32'hACE1));
        rst_n = 1'b0; en = '0; clamp = '0; mid = '0; code = '0; tgt = '0; trim = '0;
        repeat (4) tick();
        for (int c = 0; c < NCH; c++) check("R1 reset offset", ofs_of(c), 0);
        rst_n = 1'b1;
        tick();

        // R7 bypass and ignored clamp windows
        set_tgt(0, 8'h5A); set_tgt(1, 8'h11); set_tgt(2, 8'hF0);
        tick(); tick();
        check("R7 bypass ch0", ofs_of(0), 8'h5A);
        check("R7 bypass ch1", ofs_of(1), 8'h11);
        check("R7 bypass ch2", ofs_of(2), 8'hF0);
        for (int k = 0; k < 3; k++) pulse(0, 0, 2);
        check("R7 clamp ignored while off", ofs_of(0), 8'h5A);
        en = '1;
        tick(); tick();
        for (int c = 0; c < NCH; c++) check("R7 accumulator held at init", ofs_of(c), 0);

        // R4 bottom rail, R2 directions
        set_tgt(0, 8'h10);
        pulse(0, 8'hFF, 1);
        check("R4 bottom saturation", ofs_of(0), 0);
        for (int k = 0; k < 3; k++) pulse(0, 0, 1);
        check("R2 step up", ofs_of(0), 3);
        pulse(0, 8'h10, 1);
        check("R2 equal holds", ofs_of(0), 3);
        pulse(0, 8'h20, 1);
        check("R2 step down", ofs_of(0), 2);

        // R3 long window: one step, none during the window
        set_code(0, 0);
        clamp[0] = 1'b1;
        repeat (10) tick();
        check("R3 no change inside window", ofs_of(0), 2);
        repeat (10) tick();
        clamp[0] = 1'b0;
        tick(); tick();
        check("R3 single step per window", ofs_of(0), 3);

        // R6 reference select: target 0x04 reads as 0x84 at midscale
        set_tgt(0, 8'h04);
        mid[0] = 1'b1;
        pulse(0, 8'h80, 1);
        check("R6 midscale target", ofs_of(0), 4);
        mid[0] = 1'b0;
        pulse(0, 8'h80, 1);
        check("R6 ground target", ofs_of(0), 3);

        // R5 trim arithmetic
        set_tgt(0, 8'h10);
        for (int k = 0; k < 65; k++) pulse(0, 0, 1);
        check("R2 accumulate to 68", ofs_of(0), 68);
        set_trim(0, 10);  tick(); tick();
        check("R5 trim +10", ofs_of(0), 78);
        set_trim(0, -10); tick(); tick();
        check("R5 trim -10", ofs_of(0), 58);
        set_trim(0, 0);

        // R4 top rail, R5 saturating sum, R9 independence
        for (int k = 0; k < 200; k++) pulse(0, 0, 1);
        check("R4 top saturation", ofs_of(0), OMAX);
        set_trim(0, 63); tick(); tick();
        check("R5 sum clipped high", ofs_of(0), OMAX);
        check("R9 ch1 untouched", ofs_of(1), 0);
        check("R9 ch2 untouched", ofs_of(2), 0);
        set_trim(1, -64); tick(); tick();
        check("R5 sum clipped low", ofs_of(1), 0);
        set_trim(0, 0); set_trim(1, 0);

        // Seeded random phase, checked by the per-cycle model
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom % 6 == 0) clamp[c] = ~clamp[c];
                set_code(c, int'($urandom % 256));
                if ($urandom % 40 == 0) set_tgt(c, int'($urandom % 256));
                if ($urandom % 30 == 0) set_trim(c, int'($urandom % 128));
                if ($urandom % 60 == 0) mid[c] = ~mid[c];
                en[c] = ($urandom % 10) != 0;
            end
            tick();
        end

        // Closed loop with plant: code = offset + bias
        clamp = '0; en = '1; trim = '0;
        for (int c = 0; c < NCH; c++) begin
            bias[c] = int'($urandom % 81) - 40;
            goal[c] = 50 + int'($urandom % 151);
            mid[c]  = c[0];
            set_tgt(c, mid[c] ? (goal[c] ^ 128) : goal[c]);
        end
        for (int n = 0; n < 5000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                set_code(c, sat(ofs_of(c) + bias[c]));
                clamp[c] = (n % 10) < 4;
            end
            tick();
        end
        for (int c = 0; c < NCH; c++)
            check($sformatf("R2 R6 closed loop ch%0d settles", c), sat(ofs_of(c) + bias[c]), goal[c]);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule